// File: doc/BRIEF.md
# Shared-Line Interrupt Flag Aggregator

Several peripheral event signals often have to share one interrupt input of a processor core. This block merges them onto that single line. Each event has its own sticky flag bit and its own enable bit, both held in byte-wide registers. A rising edge on an event input sets the matching flag. The shared line is high while any flag is set together with its enable.

Software clears flags by writing zeros. A written 0 clears the flag in that bit position, and a written 1 leaves that flag as it is. So a handler can write a byte that is all ones except for one 0, and it clears just its own flag. Any other flag that was set in the meantime is kept.

One instance can serve a group of four clock and transfer events. A second instance can serve four metering pulse events, each group on its own shared interrupt line.

Top module: `irq_flag_agg`

## Requirements
- R1: After reset, all flags and all enables are 0, `irq_o` is 0, and `rd_data` reads 0 for both register selects.
- R2: A 0-to-1 change on `evt_i[k]`, as sampled at a clock edge, sets flag k at that edge. An input held high does not set the flag again after the flag has been cleared. The level seen before the first edge after reset counts as 0.
- R3: A write with `wr_sel`=0 (flag register) clears flag k when `wr_data[k]` is 0. Flag k is unchanged when `wr_data[k]` is 1.
- R4: When a rising edge on `evt_i[k]` and a clearing write to flag k fall in the same cycle, the flag ends up set.
- R5: A flag records its event even while its enable is 0. In that case the flag does not raise `irq_o`.
- R6: `irq_o` is high exactly when some k has both flag k and enable k set. It follows register changes in the same cycle, with no added delay.
- R7: A write with `wr_sel`=1 loads `wr_data[k]` into enable k. `rd_data` shows the flags when `rd_sel`=0 and the enables when `rd_sel`=1. Bit k corresponds to event k.
- R8: Bits `N_EVT` to 7 of `rd_data` always read 0, and writes to those bit positions have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_EVT | Event inputs, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = flags, 1 = enables |
| wr_data | input | 8 | Write byte |
| rd_sel | input | 1 | Read source: 0 = flags, 1 = enables |
| rd_data | output | 8 | Read byte |
| irq_o | output | 1 | Shared interrupt line |

## Verification
Flags and enables update at the same clock edge that samples an event edge or a write. `irq_o` and `rd_data` are combinational from those registers, so each result is due exactly one edge after its stimulus.

The bench drives inputs at the falling edge and updates its reference model at the rising edge. It then compares `irq_o` and both read selects at the next falling edge, before any new stimulus is applied. Directed cases cover the corner cases: a level held high, a set and a clear in the same cycle, and the unused bits. After them, a seeded random run compares every cycle against the model.

// File: rtl/irq_flag_agg.sv
module irq_flag_agg #(
  parameter int N_EVT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [7:0]       wr_data,
  input  logic             rd_sel,
  output logic [7:0]       rd_data,
  output logic             irq_o
);
  logic [N_EVT-1:0] evt_q, flag_q, en_q, rise;

  assign rise = evt_i & ~evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      evt_q <= evt_i;
      if (wr_en && !wr_sel) flag_q <= (flag_q & wr_data[N_EVT-1:0]) | rise;
      else                  flag_q <= flag_q | rise;
      if (wr_en && wr_sel)  en_q   <= wr_data[N_EVT-1:0];
    end
  end

  assign rd_data = 8'(rd_sel ? en_q : flag_q);
  assign irq_o   = |(flag_q & en_q);
endmodule

module irq_flag_agg_chk #(
  parameter int N_EVT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_EVT-1:0] evt_i,
  input logic [N_EVT-1:0] evt_q,
  input logic [N_EVT-1:0] flag_q,
  input logic [N_EVT-1:0] en_q,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [7:0]       wr_data,
  input logic [7:0]       rd_data,
  input logic             irq_o
);
  for (genvar k = 0; k < N_EVT; k++) begin : g_bit
    p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[k] && !evt_q[k]) |=> flag_q[k]);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[k] && !(evt_i[k] && !evt_q[k])) |=> !flag_q[k]);
    p_one_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[k] && !(wr_en && !wr_sel && !wr_data[k])) |=> flag_q[k]);
    p_zero_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && !wr_data[k] && !(evt_i[k] && !evt_q[k])) |=> !flag_q[k]);
  end

  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o);
  p_en_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (en_q == $past(wr_data[N_EVT-1:0])));
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data >> N_EVT) == 8'd0);
endmodule

bind irq_flag_agg irq_flag_agg_chk #(.N_EVT(N_EVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .evt_q(evt_q), .flag_q(flag_q),
  .en_q(en_q), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_data(rd_data), .irq_o(irq_o)
);

// File: tb/irq_flag_agg_bench.sv
`timescale 1ns/1ps
module irq_flag_agg_bench;
  localparam int N = 4;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] evt = '0;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [7:0] wr_data = '0, rd_data;
  logic irq;

  int checks = 0, errors = 0;
  logic [N-1:0] m_flag = '0, m_en = '0, m_prev = '0;

  always #10 clk = ~clk;

  irq_flag_agg #(.N_EVT(N)) u_irq_flag_agg (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq_o(irq)
  );

  function automatic logic exp_irq(logic [N-1:0] f, logic [N-1:0] e);
    return |(f & e);
  endfunction

  function automatic logic [7:0] exp_rd(logic [N-1:0] v);
    return 8'(v);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    rd_sel = 0; #1;
    chk({tag, " flags"}, rd_data, exp_rd(m_flag));
    rd_sel = 1; #1;
    chk({tag, " enables"}, rd_data, exp_rd(m_en));
    chk({tag, " R6 irq"}, 8'(irq), 8'(exp_irq(m_flag, m_en)));
  endtask

  task automatic step(logic [N-1:0] e, logic we, logic ws, logic [7:0] d);
    logic [N-1:0] rise;
    evt = e; wr_en = we; wr_sel = ws; wr_data = d;
    @(posedge clk);
    rise = e & ~m_prev;
    if (we && !ws) m_flag = (m_flag & d[N-1:0]) | rise;
    else           m_flag = m_flag | rise;
    if (we && ws)  m_en = d[N-1:0];
    m_prev = e;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1;
    @(negedge clk);
    check_all("R1 after release");

    step(4'b0000, 1, 1, 8'hFF);
    check_all("R7 enable write all");
    chk("R8 upper enable bits", rd_data, 8'h0F);
    step(4'b0000, 1, 1, 8'h00);
    check_all("R7 enable write none");

    step(4'b0010, 0, 0, 8'h00);
    check_all("R5 flag with enable off");
    chk("R5 irq low", 8'(irq), 8'h0);
    step(4'b0010, 1, 1, 8'h02);
    check_all("R6 enable raises irq");
    chk("R6 irq high", 8'(irq), 8'h1);

    step(4'b0011, 0, 0, 8'h00);
    step(4'b0011, 1, 0, 8'hFF);
    check_all("R3 ones ignored");
    chk("R3 flags kept", rd_data & 8'h0, 8'h0);
    rd_sel = 0; #1; chk("R3 flags after ones", rd_data, 8'h03);
    step(4'b0011, 1, 0, 8'hFD);
    check_all("R3 single clear");
    rd_sel = 0; #1; chk("R3 bit1 cleared", rd_data, 8'h01);
    step(4'b0011, 0, 0, 8'h00);
    rd_sel = 0; #1; chk("R2 held level no reset", rd_data, 8'h01);

    step(4'b0000, 1, 0, 8'h00);
    step(4'b0100, 1, 0, 8'h00);
    rd_sel = 0; #1; chk("R4 set beats clear", rd_data, 8'h04);
    check_all("R4 state");

    step(4'b0100, 1, 0, 8'h0F);
    rd_sel = 0; #1; chk("R8 upper flag bits", rd_data, 8'h04);
    step(4'b0100, 1, 0, 8'hF0);
    rd_sel = 0; #1; chk("R8 clear via low nibble", rd_data, 8'h00);
    chk("R6 irq low after clear", 8'(irq), 8'h0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[N-1:0], r[8] & r[9], r[10], r[23:16]);
      check_all("R2 R3 R6 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule